// File: doc/BRIEF.md
# I2C Data FIFO Pair with Threshold Ready Flags

This block holds the data bytes passing between a register bus and an I2C byte engine. A transmit queue collects bytes written by software or a DMA channel and hands them one at a time to the engine. A receive queue collects bytes produced by the engine and returns them to the bus. Each queue drives a ready flag from a selectable threshold, either one entry or four entries, so the flag can request an interrupt or a DMA burst of the matching size.

After reset the block runs in holding-register mode: each direction stores a single byte. A one-cycle enable command switches it to queue mode, normally issued right after a software reset. In queue mode each direction holds `DEPTH` bytes, and a 32-bit access moves four bytes at once. Separate flush commands empty either direction, and the two may be issued together. When the engine reports a not-acknowledge, the transmit side locks. Queued and newly written bytes stay in place and are not offered to the engine until a dedicated unlock command arrives. A bus push that does not fit is dropped and raises a sticky transmit error. An engine byte that does not fit in the receive queue is dropped and raises a sticky receive error.

Top module: `i2c_fifo_buffer`

## Requirements
- R1: After reset both levels are 0, queue mode is off, `tx_ready`=1, `rx_ready`=0, `tx_locked`=0, both error flags are 0 and `eng_tx_valid`=0.
- R2: In holding-register mode each direction holds one byte. A bus push into an occupied transmit holder is dropped and sets `tx_err`. The engine receives the accepted byte on `eng_tx_data`.
- R3: A pulse on `cmd_fifo_on` raises each direction's capacity to `DEPTH` (16) bytes. Bytes reach the engine in the order they were pushed, and a push beyond 16 is dropped.
- R4: `tx_ready` is 1 when the free space is at least 4 (`tx_thr_four`=1, queue mode) or at least 1 (`tx_thr_four`=0, or holding-register mode).
- R5: `rx_ready` is 1 when the stored count is at least 4 (`rx_thr_four`=1, queue mode) or at least 1 (otherwise).
- R6: In queue mode a wide push (`tx_wide`=1) enqueues four bytes, bits 7:0 first and bits 31:24 last. It needs four free entries, or the whole word is dropped and `tx_err` is set. In holding-register mode a wide push acts as a byte push of bits 7:0.
- R7: One cycle after a byte pop, `rx_rdata` is the oldest byte in bits 7:0 with zeros above. A wide pop in queue mode returns four bytes with the oldest in bits 7:0. It needs four stored bytes, otherwise nothing is popped and `rx_rdata` is unchanged.
- R8: A pop from an empty receive side leaves `rx_rdata` unchanged and does not set `rx_err`.
- R9: `cmd_tx_flush` and `cmd_rx_flush` empty their side and clear that side's error flag, and both may be given in one cycle. A push in the same cycle as a flush of the same side is discarded.
- R10: A pulse on `eng_nack` sets `tx_locked`. While it is set, `eng_tx_valid` is 0, the engine cannot remove bytes, and bus pushes are still queued.
- R11: Only `cmd_unlock` clears `tx_locked`. A transmit flush does not clear it.
- R12: An engine push into a full receive side is dropped and sets `rx_err`, which stays set until a receive flush.
- R13: `tx_level` and `rx_level` give the number of bytes stored in each direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_fifo_on | input | 1 | Pulse: switch to queue mode |
| cmd_tx_flush | input | 1 | Pulse: empty transmit side, clear `tx_err` |
| cmd_rx_flush | input | 1 | Pulse: empty receive side, clear `rx_err` |
| cmd_unlock | input | 1 | Pulse: clear the transmit lock |
| tx_thr_four | input | 1 | Transmit ready threshold: 1 = four free, 0 = one free |
| rx_thr_four | input | 1 | Receive ready threshold: 1 = four stored, 0 = one stored |
| tx_wr | input | 1 | Bus push strobe |
| tx_wide | input | 1 | Bus push is a 32-bit access |
| tx_wdata | input | 32 | Bus push data |
| rx_rd | input | 1 | Bus pop strobe |
| rx_wide | input | 1 | Bus pop is a 32-bit access |
| rx_rdata | output | 32 | Data of the last successful pop |
| eng_tx_valid | output | 1 | A transmit byte is offered to the engine |
| eng_tx_data | output | 8 | Offered transmit byte |
| eng_tx_take | input | 1 | Engine takes the offered byte |
| eng_nack | input | 1 | Engine saw a not-acknowledge |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| tx_ready | output | 1 | Transmit threshold flag |
| rx_ready | output | 1 | Receive threshold flag |
| tx_level | output | 5 | Transmit bytes stored |
| rx_level | output | 5 | Receive bytes stored |
| tx_locked | output | 1 | Transmit lock status |
| tx_err | output | 1 | Sticky transmit push drop |
| rx_err | output | 1 | Sticky receive overrun |

## Verification
The bench builds the block with the default depth of 16 and four byte lanes. At this depth both queues can be filled to the brim by byte and word accesses within a few dozen cycles. That puts within reach the wide push refused with only three free entries, the push into a full queue, and both threshold flags switching at the one- and four-entry boundaries. The scoreboard follows byte order across a lock, a flush during the lock and the unlock. It also follows byte order when holding-register mode is switched to queue mode.

// File: rtl/i2c_fifo_pkg.sv
package i2c_fifo_pkg;
  localparam int LANES = 4;

  // bytes moved by one bus access: 0 when idle, 4 for a wide access in queue mode
  function automatic logic [2:0] access_bytes(input logic req, input logic wide,
                                              input logic fifo_on);
    if (!req) return 3'd0;
    return (wide && fifo_on) ? 3'd4 : 3'd1;
  endfunction

  // threshold comparison shared by both ready flags
  function automatic logic meets_threshold(input int amount, input logic four,
                                           input logic fifo_on);
    return amount >= ((four && fifo_on) ? 4 : 1);
  endfunction
endpackage

// File: rtl/i2c_fifo_ring.sv
module i2c_fifo_ring #(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [2:0]         push_n,
  input  logic [LANES*8-1:0] push_data,
  input  logic [2:0]         pop_n,
  output logic [LANES*8-1:0] head,
  output logic [LW-1:0]      level
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (!flush && 3'(i) < push_n)
        mem[wr_ptr + AW'(i)] <= push_data[i*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push_n);
      rd_ptr <= rd_ptr + AW'(pop_n);
      level  <= level + LW'(push_n) - LW'(pop_n);
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_head
    assign head[l*8 +: 8] = mem[rd_ptr + AW'(l)];
  end
endmodule

// File: rtl/i2c_fifo_flag.sv
module i2c_fifo_flag #(
  parameter int LW = 5
) (
  input  logic [LW-1:0] amount,
  input  logic          four,
  input  logic          fifo_on,
  output logic          ready
);
  import i2c_fifo_pkg::*;
  assign ready = meets_threshold(int'(amount), four, fifo_on);
endmodule

// File: rtl/i2c_fifo_buffer.sv
module i2c_fifo_buffer #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_fifo_on,
  input  logic          cmd_tx_flush,
  input  logic          cmd_rx_flush,
  input  logic          cmd_unlock,
  input  logic          tx_thr_four,
  input  logic          rx_thr_four,
  input  logic          tx_wr,
  input  logic          tx_wide,
  input  logic [31:0]   tx_wdata,
  input  logic          rx_rd,
  input  logic          rx_wide,
  output logic [31:0]   rx_rdata,
  output logic          eng_tx_valid,
  output logic [7:0]    eng_tx_data,
  input  logic          eng_tx_take,
  input  logic          eng_nack,
  input  logic          eng_rx_push,
  input  logic [7:0]    eng_rx_data,
  output logic          tx_ready,
  output logic          rx_ready,
  output logic [LW-1:0] tx_level,
  output logic [LW-1:0] rx_level,
  output logic          tx_locked,
  output logic          tx_err,
  output logic          rx_err
);
  import i2c_fifo_pkg::*;

  logic          fifo_en;
  logic [LW-1:0] cap;
  logic [LW-1:0] tx_free;
  logic [2:0]    tx_req_n, tx_push_n, tx_pop_n;
  logic [2:0]    rx_req_n, rx_push_n, rx_pop_n;
  logic          tx_fit, tx_drop;
  logic          rx_fit, rx_have, rx_over;
  logic [31:0]   tx_head, rx_head;

  assign cap     = fifo_en ? LW'(DEPTH) : LW'(1);
  assign tx_free = cap - tx_level;

  // transmit side
  assign tx_req_n     = access_bytes(tx_wr, tx_wide, fifo_en);
  assign tx_fit       = int'(tx_free) >= int'(tx_req_n);
  assign tx_push_n    = (!cmd_tx_flush && tx_fit) ? tx_req_n : 3'd0;
  assign tx_drop      = tx_wr && !cmd_tx_flush && !tx_fit;
  assign eng_tx_valid = (tx_level != '0) && !tx_locked;
  assign eng_tx_data  = tx_head[7:0];
  assign tx_pop_n     = (eng_tx_take && eng_tx_valid && !cmd_tx_flush) ? 3'd1 : 3'd0;

  // receive side
  assign rx_fit    = rx_level < cap;
  assign rx_push_n = (eng_rx_push && !cmd_rx_flush && rx_fit) ? 3'd1 : 3'd0;
  assign rx_over   = eng_rx_push && !cmd_rx_flush && !rx_fit;
  assign rx_req_n  = access_bytes(rx_rd, rx_wide, fifo_en);
  assign rx_have   = int'(rx_level) >= int'(rx_req_n);
  assign rx_pop_n  = (rx_rd && !cmd_rx_flush && rx_have) ? rx_req_n : 3'd0;

  i2c_fifo_ring #(.DEPTH(DEPTH), .LANES(LANES)) u_tx_ring (
    .clk(clk), .rst_n(rst_n), .flush(cmd_tx_flush),
    .push_n(tx_push_n), .push_data(tx_wdata), .pop_n(tx_pop_n),
    .head(tx_head), .level(tx_level)
  );

  i2c_fifo_ring #(.DEPTH(DEPTH), .LANES(LANES)) u_rx_ring (
    .clk(clk), .rst_n(rst_n), .flush(cmd_rx_flush),
    .push_n(rx_push_n), .push_data({24'd0, eng_rx_data}), .pop_n(rx_pop_n),
    .head(rx_head), .level(rx_level)
  );

  i2c_fifo_flag #(.LW(LW)) u_tx_flag (
    .amount(tx_free), .four(tx_thr_four), .fifo_on(fifo_en), .ready(tx_ready)
  );

  i2c_fifo_flag #(.LW(LW)) u_rx_flag (
    .amount(rx_level), .four(rx_thr_four), .fifo_on(fifo_en), .ready(rx_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en   <= 1'b0;
      tx_locked <= 1'b0;
      tx_err    <= 1'b0;
      rx_err    <= 1'b0;
      rx_rdata  <= '0;
    end else begin
      if (cmd_fifo_on) fifo_en <= 1'b1;
      tx_locked <= eng_nack || (tx_locked && !cmd_unlock);
      if (cmd_tx_flush)  tx_err <= 1'b0;
      else if (tx_drop)  tx_err <= 1'b1;
      if (cmd_rx_flush)  rx_err <= 1'b0;
      else if (rx_over)  rx_err <= 1'b1;
      if (rx_pop_n == 3'd4)      rx_rdata <= rx_head;
      else if (rx_pop_n == 3'd1) rx_rdata <= {24'd0, rx_head[7:0]};
    end
  end
endmodule

// File: rtl/i2c_fifo_checker.sv
module i2c_fifo_checker #(
  parameter int DEPTH = 16,
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          tx_drop,
  input logic          cmd_tx_flush,
  input logic          cmd_rx_flush,
  input logic          cmd_unlock,
  input logic          rx_rd,
  input logic          eng_tx_valid,
  input logic          tx_locked,
  input logic          tx_err,
  input logic          rx_err,
  input logic [31:0]   rx_rdata,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level
);
  // R3: levels never exceed the capacity of the current mode
  p_level_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tx_level) <= (fifo_en ? DEPTH : 1)) && (int'(rx_level) <= (fifo_en ? DEPTH : 1)));

  p_lock_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_locked |-> !eng_tx_valid);

  p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_locked && !cmd_unlock |=> tx_locked);

  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_tx_flush |=> tx_level == '0);

  p_rx_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rx_flush |=> rx_level == '0 && !rx_err);

  p_drop_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop |=> tx_err);

  p_overrun_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err && !cmd_rx_flush |=> rx_err);

  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd && rx_level == '0 && !cmd_rx_flush |=> $stable(rx_rdata) && $stable(rx_err));
endmodule

bind i2c_fifo_buffer i2c_fifo_checker #(.DEPTH(DEPTH), .LW(LW)) u_checker (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_drop(tx_drop),
  .cmd_tx_flush(cmd_tx_flush), .cmd_rx_flush(cmd_rx_flush), .cmd_unlock(cmd_unlock),
  .rx_rd(rx_rd), .eng_tx_valid(eng_tx_valid), .tx_locked(tx_locked),
  .tx_err(tx_err), .rx_err(rx_err), .rx_rdata(rx_rdata),
  .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/tb_i2c_fifo_buffer.sv
module tb_i2c_fifo_buffer;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_fifo_on = 0, cmd_tx_flush = 0, cmd_rx_flush = 0, cmd_unlock = 0;
  logic tx_thr_four = 0, rx_thr_four = 0;
  logic tx_wr = 0, tx_wide = 0, rx_rd = 0, rx_wide = 0;
  logic [31:0] tx_wdata = 0;
  logic [31:0] rx_rdata;
  logic eng_tx_valid, eng_tx_take = 0, eng_nack = 0, eng_rx_push = 0;
  logic [7:0] eng_tx_data, eng_rx_data = 0;
  logic tx_ready, rx_ready, tx_locked, tx_err, rx_err;
  logic [4:0] tx_level, rx_level;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] tx_q[$];

  always #(PERIOD/2) clk = ~clk;

  i2c_fifo_buffer dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    cmd_fifo_on = 0; cmd_tx_flush = 0; cmd_rx_flush = 0; cmd_unlock = 0;
    tx_wr = 0; tx_wide = 0; rx_rd = 0; rx_wide = 0;
    eng_tx_take = 0; eng_nack = 0; eng_rx_push = 0;
  endtask

  // driver: bus push, recording the bytes the requirements say are accepted
  task automatic push_tx(logic [31:0] d, bit wide, bit ok, int nbytes);
    tx_wr = 1; tx_wide = wide; tx_wdata = d;
    if (ok) for (int i = 0; i < nbytes; i++) tx_q.push_back(d[i*8 +: 8]);
    tick();
  endtask

  task automatic take(int n);
    for (int i = 0; i < n; i++) begin eng_tx_take = 1; tick(); end
  endtask

  task automatic push_rx(logic [7:0] b);
    eng_rx_push = 1; eng_rx_data = b; tick();
  endtask

  task automatic pop_rx(bit wide);
    rx_rd = 1; rx_wide = wide; tick();
  endtask

  // monitor: every byte the engine takes is compared with the scoreboard
  always @(negedge clk) begin
    if (rst_n && eng_tx_take && eng_tx_valid) begin
      if (tx_q.size() == 0) check("R3 tx order (unexpected byte)", {24'd0, eng_tx_data}, 32'hxx);
      else check("R3 tx order", {24'd0, eng_tx_data}, {24'd0, tx_q.pop_front()});
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    check("R1 tx_level", tx_level, 0);
    check("R1 rx_level", rx_level, 0);
    check("R1 tx_ready", tx_ready, 1);
    check("R1 rx_ready", rx_ready, 0);
    check("R1 lock/err", {tx_locked, tx_err, rx_err, eng_tx_valid}, 0);

    // R2 holding-register mode, transmit
    push_tx(32'hA5, 0, 1, 1);
    check("R2 level one", tx_level, 1);
    check("R4 holding full not ready", tx_ready, 0);
    push_tx(32'h5A, 0, 0, 1);
    check("R2 second push dropped", {tx_err, 3'd0, tx_level}, {1'b1, 3'd0, 5'd1});
    take(1);
    check("R2 drained", tx_level, 0);
    push_tx(32'hDDCCBBC3, 1, 1, 1);
    check("R6 wide in holding acts as byte", tx_level, 1);
    take(1);
    cmd_tx_flush = 1; tick();
    check("R9 tx flush clears tx_err", tx_err, 0);

    // R2/R12 holding-register mode, receive
    push_rx(8'h11);
    check("R5 rx holding ready", {rx_ready, 3'd0, rx_level}, {1'b1, 3'd0, 5'd1});
    push_rx(8'h22);
    check("R12 holding overrun", {rx_err, 3'd0, rx_level}, {1'b1, 3'd0, 5'd1});
    pop_rx(0);
    check("R7 byte pop", rx_rdata, 32'h11);
    cmd_rx_flush = 1; tick();
    pop_rx(0);
    check("R8 empty pop rdata", rx_rdata, 32'h11);
    check("R8 empty pop no error", rx_err, 0);

    // R3 queue mode, transmit
    cmd_fifo_on = 1; tick();
    tx_thr_four = 1; #1;
    check("R4 empty queue ready four", tx_ready, 1);
    push_tx(32'h44332211, 1, 1, 4);
    check("R6 wide push level", tx_level, 4);
    for (int i = 0; i < 9; i++) push_tx(32'h50 + i, 0, 1, 1);
    check("R13 tx level 13", tx_level, 13);
    check("R4 three free four mode", tx_ready, 0);
    tx_thr_four = 0; #1;
    check("R4 three free one mode", tx_ready, 1);
    tx_thr_four = 1;
    push_tx(32'hDEADBEEF, 1, 0, 4);
    check("R6 wide drop level", tx_level, 13);
    check("R6 wide drop error", tx_err, 1);
    for (int i = 0; i < 3; i++) push_tx(32'h60 + i, 0, 1, 1);
    push_tx(32'h63, 0, 0, 1);
    check("R3 capacity sixteen", tx_level, 16);
    take(5);
    check("R13 tx level after take", tx_level, 11);

    // R10/R11 lock
    eng_nack = 1; tick();
    check("R10 locked", {tx_locked, eng_tx_valid}, 2'b10);
    take(3);
    check("R10 no drain while locked", tx_level, 11);
    cmd_tx_flush = 1; tick();
    tx_q.delete();
    check("R11 flush keeps lock", {tx_locked, 3'd0, tx_level}, {1'b1, 3'd0, 5'd0});
    push_tx(32'h71, 0, 1, 1);
    push_tx(32'h72, 0, 1, 1);
    check("R10 push while locked", {eng_tx_valid, 3'd0, tx_level}, {1'b0, 3'd0, 5'd2});
    cmd_unlock = 1; tick();
    check("R11 unlock", {tx_locked, eng_tx_valid}, 2'b01);
    take(2);
    check("R3 drained after unlock", tx_level, 0);

    // R5/R7 queue mode, receive
    rx_thr_four = 1;
    push_rx(8'hA1); push_rx(8'hA2); push_rx(8'hA3);
    check("R5 three stored four mode", {rx_ready, 3'd0, rx_level}, {1'b0, 3'd0, 5'd3});
    push_rx(8'hA4);
    check("R5 four stored", rx_ready, 1);
    pop_rx(1);
    check("R7 wide pop data", rx_rdata, 32'hA4A3A2A1);
    check("R7 wide pop level", rx_level, 0);
    push_rx(8'hB1); push_rx(8'hB2);
    pop_rx(1);
    check("R7 short wide pop ignored", rx_rdata, 32'hA4A3A2A1);
    check("R7 short wide pop level", rx_level, 2);
    pop_rx(0);
    check("R7 byte pop in queue mode", rx_rdata, 32'hB1);
    rx_thr_four = 0; #1;
    check("R5 one stored one mode", rx_ready, 1);
    for (int i = 0; i < 15; i++) push_rx(8'hC0 + 8'(i));
    check("R13 rx full", rx_level, 16);
    push_rx(8'hEE);
    check("R12 queue overrun", {rx_err, 3'd0, rx_level}, {1'b1, 3'd0, 5'd16});

    // R9 combined flush and flush-beats-push
    push_tx(32'h81, 0, 0, 1);
    push_tx(32'h82, 0, 0, 1);
    tx_q.delete();
    cmd_tx_flush = 1; cmd_rx_flush = 1; eng_rx_push = 1; eng_rx_data = 8'h99;
    tx_wr = 1; tx_wdata = 32'h83; tick();
    check("R9 both flushed", {tx_level, rx_level}, 10'd0);
    check("R9 rx_err cleared", rx_err, 0);
    check("R3 scoreboard empty", tx_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule